// File: doc/BRIEF.md
# Zero-and-Frequent-Value Line Compressor

This block shrinks one 64-byte memory line before it is written to a non-volatile main memory. The line is cut into 32 sub-blocks of 16 bits each. For every sub-block the block notes whether it is all zero. It also checks whether the sub-block matches one of a small set of common values. From these facts it works out the encoded size of three compression schemes. It then keeps the scheme with the fewest bytes. If none of them beats the 64-byte raw line, the line is passed through unchanged.

A line enters on a valid/ready handshake and is compressed in a single cycle. The result is held in one output register: a packed payload, its length in whole bytes, and a 2-bit tag that names the scheme. The output follows the same valid/ready protocol, so a stalled consumer holds the result in place until it takes it. Placing the payload inside the stored line and generating error-correction bits are done elsewhere.

Top module: `lc_line_compressor`

## Requirements
- R1: Sub-block i is `in_line[16*i+15 : 16*i]`. The zero map holds one bit per sub-block: bit i is 1 exactly when sub-block i is all zero. When the map is part of the payload it sits in payload bits 31:0.
- R2: Zero-only scheme (tag 01). The payload is the zero map, followed by the 16-bit value of each non-zero sub-block in ascending sub-block order, starting at bit 32. The size is 4 + 2·(non-zero count) bytes.
- R3: The zero-only scheme is never selected unless more than 2 sub-blocks are zero.
- R4: Frequent-value-only scheme (tag 10). Sub-block i gets a 3-bit code at payload bits 3i+2:3i. Codes 001 to 111 stand for the values 0, 1, 2, 4, 3, 0xFFFF (-1) and 5. Code 000 marks a literal. The literals follow from bit 96 in sub-block order. The size is 12 + 2·(literal count) bytes.
- R5: Combined scheme (tag 11). The payload is the zero map, then one 3-bit code per non-zero sub-block in sub-block order, then the literals in sub-block order. Codes 001 to 111 stand for 1, 2, 4, 3, 0xFFFF, 5 and 8. Code 000 marks a literal. The size is ceil((32 + 3·nonzero + 16·literals)/8) bytes.
- R6: The block selects the scheme with the smallest byte size. On a tie the lower tag wins. When no scheme is below 64 bytes, it outputs tag 00 with size 64, and the payload equals the input line.
- R7: The tag encoding is 00 raw, 01 zero-only, 10 frequent-value-only and 11 combined.
- R8: Every payload bit at or above 8·size is zero.
- R9: `in_ready` is high when the output register is empty or `out_ready` is high. An accepted line's result appears with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, the outputs hold steady and new input is not taken.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A line is offered |
| in_ready | output | 1 | The block can take a line this cycle |
| in_line | input | 512 | Uncompressed line, sub-block 0 in the low bits |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_valid | output | 1 | A compressed result is held |
| out_payload | output | 512 | Packed encoded line, LSB first, zero padded |
| out_bytes | output | 7 | Payload length in bytes (1 to 64) |
| out_tag | output | 2 | Scheme tag |

## Verification
The bench builds the block with its default parameters: 16-bit sub-blocks, 32 per line and 3-bit codes. With these values the code table is filled completely, and the 4-byte zero map breaks even at exactly two zero sub-blocks. That makes the R3 threshold, the byte-rounding of the combined size, and ties between schemes (for example 12 bytes for both frequent-value-only and combined) reachable with hand-built lines. The same setting also reaches lines that fall back to raw and a stall with a competing input held high.

// File: rtl/lc_pkg.sv
package lc_pkg;

    typedef enum logic [1:0] {
        TAG_RAW  = 2'b00,
        TAG_ZERO = 2'b01,
        TAG_FREQ = 2'b10,
        TAG_BOTH = 2'b11
    } lc_tag_e;

    // Common sub-block values by rank; rank r is the r-th most frequent.
    function automatic int lc_rank_value(input int rank);
        case (rank)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 4;
            4:       return 3;
            5:       return -1;
            6:       return 5;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/lc_classify.sv
module lc_classify #(
    parameter int SUB_W  = 16,
    parameter int N_SUB  = 32,
    parameter int CODE_W = 3
) (
    input  logic [SUB_W*N_SUB-1:0]  line_i,
    output logic [N_SUB-1:0]        zero_map_o,
    output logic [N_SUB*CODE_W-1:0] fv_code_o,
    output logic [N_SUB*CODE_W-1:0] cb_code_o
);
    localparam int N_CODES = 1 << CODE_W;

    for (genvar g = 0; g < N_SUB; g++) begin : g_sub
        logic [SUB_W-1:0]  sub;
        logic [CODE_W-1:0] fv_c;
        logic [CODE_W-1:0] cb_c;

        assign sub = line_i[g*SUB_W +: SUB_W];
        assign zero_map_o[g] = (sub == '0);

        // Frequent-only codes cover ranks 0..N-2; combined codes skip zero
        // and cover ranks 1..N-1. Code 0 is the literal escape in both.
        always_comb begin
            fv_c = '0;
            cb_c = '0;
            for (int k = N_CODES - 1; k >= 1; k--) begin
                if (sub == SUB_W'(lc_pkg::lc_rank_value(k - 1))) fv_c = CODE_W'(k);
                if (sub == SUB_W'(lc_pkg::lc_rank_value(k)))     cb_c = CODE_W'(k);
            end
        end

        assign fv_code_o[g*CODE_W +: CODE_W] = fv_c;
        assign cb_code_o[g*CODE_W +: CODE_W] = cb_c;
    end

endmodule

// File: rtl/lc_sizer.sv
module lc_sizer #(
    parameter int SUB_W  = 16,
    parameter int N_SUB  = 32,
    parameter int CODE_W = 3,
    parameter int BYTE_W = 7
) (
    input  logic [N_SUB-1:0]        zero_map_i,
    input  logic [N_SUB*CODE_W-1:0] fv_code_i,
    input  logic [N_SUB*CODE_W-1:0] cb_code_i,
    output lc_pkg::lc_tag_e         tag_o,
    output logic [BYTE_W-1:0]       bytes_o
);
    import lc_pkg::*;

    localparam int LINE_BYTES = SUB_W * N_SUB / 8;
    localparam int MAX_BITS   = N_SUB * (1 + 2 * CODE_W + SUB_W) + 8;
    localparam int BIT_W      = $clog2(MAX_BITS + 1) + 1;
    localparam int CNT_W      = $clog2(N_SUB + 1);

    logic [CNT_W-1:0] zeros_d;
    logic [CNT_W-1:0] nonzero_d;
    logic [CNT_W-1:0] fv_lits_d;
    logic [CNT_W-1:0] cb_lits_d;
    logic [BIT_W-1:0] zd_bytes_d;
    logic [BIT_W-1:0] fv_bytes_d;
    logic [BIT_W-1:0] cb_bytes_d;
    logic             zero_ok_d;

    function automatic logic [BIT_W-1:0] to_bytes(input logic [BIT_W-1:0] bits);
        return (bits + BIT_W'(7)) >> 3;
    endfunction

    always_comb begin
        zeros_d   = '0;
        fv_lits_d = '0;
        cb_lits_d = '0;
        for (int i = 0; i < N_SUB; i++) begin
            zeros_d   = zeros_d + CNT_W'(zero_map_i[i]);
            fv_lits_d = fv_lits_d + CNT_W'(fv_code_i[i*CODE_W +: CODE_W] == '0);
            cb_lits_d = cb_lits_d +
                        CNT_W'(!zero_map_i[i] && (cb_code_i[i*CODE_W +: CODE_W] == '0));
        end
        nonzero_d  = CNT_W'(N_SUB) - zeros_d;
        // The map pays for itself only when the zeros it removes outweigh it.
        zero_ok_d  = (BIT_W'(zeros_d) * BIT_W'(SUB_W)) > BIT_W'(N_SUB);
        zd_bytes_d = to_bytes(BIT_W'(N_SUB) + BIT_W'(nonzero_d) * BIT_W'(SUB_W));
        fv_bytes_d = to_bytes(BIT_W'(N_SUB * CODE_W) + BIT_W'(fv_lits_d) * BIT_W'(SUB_W));
        cb_bytes_d = to_bytes(BIT_W'(N_SUB) + BIT_W'(nonzero_d) * BIT_W'(CODE_W)
                              + BIT_W'(cb_lits_d) * BIT_W'(SUB_W));
    end

    // Strict compares in tag order: ties keep the lower tag.
    always_comb begin
        logic [BIT_W-1:0] best;
        best  = BIT_W'(LINE_BYTES);
        tag_o = TAG_RAW;
        if (zero_ok_d && (zd_bytes_d < best)) begin
            best  = zd_bytes_d;
            tag_o = TAG_ZERO;
        end
        if (fv_bytes_d < best) begin
            best  = fv_bytes_d;
            tag_o = TAG_FREQ;
        end
        if (cb_bytes_d < best) begin
            best  = cb_bytes_d;
            tag_o = TAG_BOTH;
        end
        bytes_o = BYTE_W'(best);
    end

endmodule

// File: rtl/lc_packer.sv
module lc_packer #(
    parameter int SUB_W  = 16,
    parameter int N_SUB  = 32,
    parameter int CODE_W = 3
) (
    input  logic [SUB_W*N_SUB-1:0]  line_i,
    input  logic [N_SUB-1:0]        zero_map_i,
    input  logic [N_SUB*CODE_W-1:0] fv_code_i,
    input  logic [N_SUB*CODE_W-1:0] cb_code_i,
    input  lc_pkg::lc_tag_e         tag_i,
    output logic [SUB_W*N_SUB-1:0]  payload_o
);
    import lc_pkg::*;

    localparam int LINE_W = SUB_W * N_SUB;
    localparam int IDX_W  = $clog2(LINE_W);

    always_comb begin : pack_p
        int pos;
        pos       = 0;
        payload_o = '0;
        case (tag_i)
            TAG_RAW: payload_o = line_i;
            TAG_ZERO: begin
                payload_o[N_SUB-1:0] = zero_map_i;
                pos = N_SUB;
                for (int i = 0; i < N_SUB; i++) begin
                    if (!zero_map_i[i]) begin
                        if (pos + SUB_W <= LINE_W)
                            payload_o[pos[IDX_W-1:0] +: SUB_W] = line_i[i*SUB_W +: SUB_W];
                        pos = pos + SUB_W;
                    end
                end
            end
            TAG_FREQ: begin
                payload_o[N_SUB*CODE_W-1:0] = fv_code_i;
                pos = N_SUB * CODE_W;
                for (int i = 0; i < N_SUB; i++) begin
                    if (fv_code_i[i*CODE_W +: CODE_W] == '0) begin
                        if (pos + SUB_W <= LINE_W)
                            payload_o[pos[IDX_W-1:0] +: SUB_W] = line_i[i*SUB_W +: SUB_W];
                        pos = pos + SUB_W;
                    end
                end
            end
            default: begin
                payload_o[N_SUB-1:0] = zero_map_i;
                pos = N_SUB;
                for (int i = 0; i < N_SUB; i++) begin
                    if (!zero_map_i[i]) begin
                        if (pos + CODE_W <= LINE_W)
                            payload_o[pos[IDX_W-1:0] +: CODE_W] = cb_code_i[i*CODE_W +: CODE_W];
                        pos = pos + CODE_W;
                    end
                end
                for (int i = 0; i < N_SUB; i++) begin
                    if (!zero_map_i[i] && (cb_code_i[i*CODE_W +: CODE_W] == '0)) begin
                        if (pos + SUB_W <= LINE_W)
                            payload_o[pos[IDX_W-1:0] +: SUB_W] = line_i[i*SUB_W +: SUB_W];
                        pos = pos + SUB_W;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/lc_line_compressor.sv
module lc_line_compressor #(
    parameter int SUB_W  = 16,
    parameter int N_SUB  = 32,
    parameter int CODE_W = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [SUB_W*N_SUB-1:0]               in_line,
    input  logic                                 out_ready,
    output logic                                 out_valid,
    output logic [SUB_W*N_SUB-1:0]               out_payload,
    output logic [$clog2(SUB_W*N_SUB/8+1)-1:0]   out_bytes,
    output logic [1:0]                           out_tag
);
    import lc_pkg::*;

    localparam int LINE_W     = SUB_W * N_SUB;
    localparam int LINE_BYTES = LINE_W / 8;
    localparam int BYTE_W     = $clog2(LINE_BYTES + 1);
    localparam int MAP_BYTES  = N_SUB / 8;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] payload;
        logic [BYTE_W-1:0] bytes;
        logic [1:0]        tag;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [N_SUB-1:0]        zero_map;
    logic [N_SUB*CODE_W-1:0] fv_code;
    logic [N_SUB*CODE_W-1:0] cb_code;
    lc_tag_e                 sel_tag;
    logic [BYTE_W-1:0]       sel_bytes;
    logic [LINE_W-1:0]       packed_line;

    lc_classify #(.SUB_W(SUB_W), .N_SUB(N_SUB), .CODE_W(CODE_W)) u_classify (
        .line_i     (in_line),
        .zero_map_o (zero_map),
        .fv_code_o  (fv_code),
        .cb_code_o  (cb_code)
    );

    lc_sizer #(.SUB_W(SUB_W), .N_SUB(N_SUB), .CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_sizer (
        .zero_map_i (zero_map),
        .fv_code_i  (fv_code),
        .cb_code_i  (cb_code),
        .tag_o      (sel_tag),
        .bytes_o    (sel_bytes)
    );

    lc_packer #(.SUB_W(SUB_W), .N_SUB(N_SUB), .CODE_W(CODE_W)) u_packer (
        .line_i     (in_line),
        .zero_map_i (zero_map),
        .fv_code_i  (fv_code),
        .cb_code_i  (cb_code),
        .tag_i      (sel_tag),
        .payload_o  (packed_line)
    );

    assign in_ready = !st_q.valid || out_ready;

    always_comb begin
        st_d = st_q;
        if (in_valid && in_ready) begin
            st_d.valid   = 1'b1;
            st_d.payload = packed_line;
            st_d.bytes   = sel_bytes;
            st_d.tag     = sel_tag;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_payload = st_q.payload;
    assign out_bytes   = st_q.bytes;
    assign out_tag     = st_q.tag;

    // R9: a held result does not move while the consumer stalls
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)
                                       && $stable(out_bytes) && $stable(out_tag)));

    // R9: a taken line produces a result on the next cycle
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R3: the zero-only scheme needs more than the break-even count of zeros
    p_zero_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == TAG_ZERO)
            |-> ($countones(out_payload[N_SUB-1:0]) * SUB_W > N_SUB));

    // R2: zero-only size follows from the map carried in the payload
    p_zero_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == TAG_ZERO)
            |-> (32'(out_bytes) == MAP_BYTES
                 + (SUB_W / 8) * (N_SUB - $countones(out_payload[N_SUB-1:0]))));

    // R6: a compressed tag always means a smaller line; raw means full size
    p_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag != TAG_RAW) |-> (32'(out_bytes) < LINE_BYTES));

    p_raw_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == TAG_RAW) |-> (32'(out_bytes) == LINE_BYTES));

    // R8: nothing is left above the reported length
    p_tail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag != TAG_RAW)
            |-> ((out_payload >> (32'(out_bytes) * 8)) == '0));

endmodule

// File: tb/lc_line_compressor_bench.sv
`timescale 1ns/1ps
module lc_line_compressor_bench;

    localparam int NV = 12;

    // Vector table: zero mask, literal mask, fill value, expected tag, bytes.
    localparam logic [31:0] ZM [NV] = '{
        32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF,
        32'h0000_0003, 32'h0000_0007, 32'h0000_0FFF, 32'h0000_3FFF,
        32'hFF00_0000, 32'h000F_FFFF, 32'h7FFF_FFFF, 32'hFFFF_FFFE };
    localparam logic [31:0] LM [NV] = '{
        32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000,
        32'h0000_000F, 32'h0030_0000, 32'h0000_0000, 32'h0000_0001 };
    localparam logic [15:0] FV [NV] = '{
        16'h0001, 16'h0001, 16'h0001, 16'h0008,
        16'h0001, 16'h0001, 16'hFFFF, 16'hFFFF,
        16'h0005, 16'h0003, 16'h0004, 16'h0004 };
    localparam logic [1:0] ET [NV] = '{
        2'b01, 2'b10, 2'b00, 2'b11, 2'b00, 2'b01,
        2'b10, 2'b11, 2'b10, 2'b11, 2'b11, 2'b01 };
    localparam int EB [NV] = '{ 4, 12, 64, 10, 64, 62, 12, 11, 20, 13, 5, 6 };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [511:0] in_line = '0;
    logic         out_ready = 1'b1;
    logic         out_valid;
    logic [511:0] out_payload;
    logic [6:0]   out_bytes;
    logic [1:0]   out_tag;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lc_line_compressor u_lc_line_compressor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .out_ready(out_ready), .out_valid(out_valid),
        .out_payload(out_payload), .out_bytes(out_bytes), .out_tag(out_tag)
    );

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] mk_line(input logic [31:0] zm, input logic [31:0] lm,
                                             input logic [15:0] fill);
        logic [511:0] l = '0;
        for (int i = 0; i < 32; i++)
            l[16*i +: 16] = zm[i] ? 16'h0 : (lm[i] ? 16'h1234 + 16'(i) : fill);
        return l;
    endfunction

    function automatic logic [2:0] fcode(input logic [15:0] s);
        case (s)
            16'h0000: return 3'd1;
            16'h0001: return 3'd2;
            16'h0002: return 3'd3;
            16'h0004: return 3'd4;
            16'h0003: return 3'd5;
            16'hFFFF: return 3'd6;
            16'h0005: return 3'd7;
            default:  return 3'd0;
        endcase
    endfunction

    function automatic logic [2:0] ccode(input logic [15:0] s);
        case (s)
            16'h0001: return 3'd1;
            16'h0002: return 3'd2;
            16'h0004: return 3'd3;
            16'h0003: return 3'd4;
            16'hFFFF: return 3'd5;
            16'h0005: return 3'd6;
            16'h0008: return 3'd7;
            default:  return 3'd0;
        endcase
    endfunction

    // Reference payload, built by appending fields one bit at a time.
    function automatic logic [511:0] model(input logic [511:0] ln, input logic [1:0] tg);
        logic [511:0] p = '0;
        int pos = 0;
        logic [15:0] s;
        logic [2:0] c;
        if (tg == 2'b00) return ln;
        if (tg != 2'b10) begin
            for (int i = 0; i < 32; i++) begin
                p[pos] = (ln[16*i +: 16] == 16'h0);
                pos++;
            end
        end
        for (int i = 0; i < 32; i++) begin
            s = ln[16*i +: 16];
            if (tg == 2'b10 || (tg == 2'b11 && s != 16'h0)) begin
                c = (tg == 2'b10) ? fcode(s) : ccode(s);
                for (int b = 0; b < 3; b++) begin
                    if (pos < 512) p[pos] = c[b];
                    pos++;
                end
            end
        end
        for (int i = 0; i < 32; i++) begin
            s = ln[16*i +: 16];
            if ((tg == 2'b01 && s != 16'h0) || (tg == 2'b10 && fcode(s) == 3'd0)
                || (tg == 2'b11 && s != 16'h0 && ccode(s) == 3'd0)) begin
                for (int b = 0; b < 16; b++) begin
                    if (pos < 512) p[pos] = s[b];
                    pos++;
                end
            end
        end
        return p;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] l;
        logic [511:0] hold_p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 out_valid after reset", 512'(out_valid), 512'(0));
        chk("R10 in_ready after reset", 512'(in_ready), 512'(1));

        // Table walk: R1..R8 across patterns
        for (int v = 0; v < NV; v++) begin
            l = mk_line(ZM[v], LM[v], FV[v]);
            in_line  = l;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R9 vec%0d out_valid", v), 512'(out_valid), 512'(1));
            chk($sformatf("R6/R7 vec%0d tag", v), 512'(out_tag), 512'(ET[v]));
            chk($sformatf("R2/R4/R5/R6 vec%0d bytes", v), 512'(out_bytes), 512'(EB[v]));
            chk($sformatf("R1/R2/R4/R5/R8 vec%0d payload", v), out_payload, model(l, ET[v]));
        end
        @(negedge clk);
        chk("R9 drains when taken", 512'(out_valid), 512'(0));

        // R3 boundary: two zeros are not enough, three are
        chk("R3 two zeros gives raw", 512'(ET[4]), 512'(2'b00));

        // R9 stall: result held, competing line not taken
        out_ready = 1'b0;
        l = mk_line(ZM[3], LM[3], FV[3]);
        in_line  = l;
        in_valid = 1'b1;
        @(negedge clk);
        hold_p = out_payload;
        chk("R9 stall in_ready low", 512'(in_ready), 512'(0));
        chk("R9 stall tag", 512'(out_tag), 512'(2'b11));
        in_line = mk_line(ZM[1], LM[1], FV[1]);
        repeat (3) @(negedge clk);
        chk("R9 held payload", out_payload, hold_p);
        chk("R9 held bytes", 512'(out_bytes), 512'(10));
        chk("R9 held valid", 512'(out_valid), 512'(1));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 next line tag", 512'(out_tag), 512'(2'b10));
        chk("R9 next line bytes", 512'(out_bytes), 512'(12));
        @(negedge clk);
        chk("R9 empty after take", 512'(out_valid), 512'(0));

        // R10: reset clears a held result
        out_ready = 1'b0;
        in_line  = mk_line(ZM[0], LM[0], FV[0]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset drops result", 512'(out_valid), 512'(0));
        chk("R10 ready after reset", 512'(in_ready), 512'(1));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule